// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is a 24-pin general-purpose I/O port that a host controls over a simple byte-wide register bus. The pins are grouped into three byte-wide banks. For every pin the register file holds a direction bit, an output-type bit and a pull-select bit. It also holds an output latch, which changes only through two write-one registers: one sets latch bits and one clears them. Reading a state bank returns the live pin levels after a two-flop synchronizer.

Each pin has a pad-control decoder. It turns the three configuration bits and the latch into six pad signals: drive value, drive enable, open-drain select, pull-up enable, pull-down enable and analog mode. Pins 0 to 15 are always usable. Pins 16 to 19 and pins 20 to 23 each belong to a group that needs its own enable input before those pins act as GPIO. The serial host link and the analog pad circuits sit outside this block.

The block has no state machine. Every register is a plain bank of flops and every pad output is combinational from those flops.

Top module: `gpio_port`

## Requirements
- R1: Pin n maps to bank n/8 at bit n%8 in every bank family. For example, pin 10 is bit 2 of the second bank.
- R2: The state banks at 0x10, 0x11 and 0x12 return the pin inputs after two clock edges of synchronization. They are read-only: writes to them change nothing.
- R3: The direction banks sit at 0x60, 0x61 and 0x63. A bit value of 1 makes the pin an output and 0 makes it an input. Address 0x62 holds no register: writes there change nothing and reads return 0x00.
- R4: The output-type banks at 0x64 to 0x66 and the pull-select banks at 0x68 to 0x6A read back the last byte written to them.
- R5: Writing a byte to a set bank (0x6C to 0x6E) forces each latch bit that has a 1 in the byte to 1 and leaves the other latch bits unchanged. Reading a set-bank address returns that bank's latch byte.
- R6: Writing a byte to a clear bank (0x70 to 0x72) forces each latch bit that has a 1 in the byte to 0 and leaves the other latch bits unchanged. Reading a clear-bank address returns that bank's latch byte.
- R7: An enabled output pin has pad_oe=1, and pad_out equals its latch bit.
  - With type 0 the pin is push-pull: pad_od, pad_pu, pad_pd and pad_ana are all 0.
  - With type 1 the pin is open-drain: pad_od=1, pad_pu equals the pull-select bit, and pad_pd=0 and pad_ana=0.
- R8: An enabled input pin has pad_oe=0, pad_out=0 and pad_od=0.
  - With type 1, pull-select 1 gives pad_pu=1 and pull-select 0 gives pad_pd=1.
  - With type 0, pull-select 0 gives pad_ana=1, and pull-select 1 leaves the pin floating with all pad signals 0.
- R9: Pins 16 to 19 need grp_en[0] and pins 20 to 23 need grp_en[1]. While its group is disabled, a pin drives all six pad signals to 0 and reads 0 in its state bank. Its configuration bits and latch bit are kept.
- R10: After reset all direction, type, pull-select and latch bits are 0. Every enabled pin is then an analog input (pad_ana=1, pad_oe=0).
- R11: rdata is 0x00 whenever rd_en is low, and when rd_en is high with any address that holds no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| grp_en | input | 2 | Enables for pin groups 16-19 and 20-23 |
| pin_in | input | 24 | Asynchronous pin levels from the pads |
| pad_out | output | 24 | Drive value per pin |
| pad_oe | output | 24 | Drive enable per pin |
| pad_od | output | 24 | Open-drain select per pin |
| pad_pu | output | 24 | Pull-up enable per pin |
| pad_pd | output | 24 | Pull-down enable per pin |
| pad_ana | output | 24 | Analog mode per pin |

## Verification
Some properties are checked by assertions on every cycle:
- a pin never enables pull-up and pull-down together;
- a driving pin never has pull-down or analog mode active;
- a pin in a disabled group stays fully quiet;
- a set write only raises latch bits, a clear write only lowers them, and the latch holds when neither strobe is active.

Other behaviours need the bench's reference model, compared on every clock:
- the exact register address map, including the hole at 0x62;
- the two-edge synchronizer delay;
- the full table of six pad signals for each combination of the three configuration bits;
- the value read back once group enables are withdrawn.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam logic [7:0] BASE_STATE = 8'h10;
    localparam logic [7:0] BASE_DIR   = 8'h60;
    localparam logic [7:0] BASE_TYPE  = 8'h64;
    localparam logic [7:0] BASE_PULL  = 8'h68;
    localparam logic [7:0] BASE_SET   = 8'h6C;
    localparam logic [7:0] BASE_CLR   = 8'h70;
    localparam int         DIR_HOLE   = 2;   // direction map skips one address here

    // Address of direction bank b (the map has a hole before the third bank).
    function automatic logic [7:0] dir_addr(input int b);
        return BASE_DIR + 8'(b) + ((b >= DIR_HOLE) ? 8'd1 : 8'd0);
    endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_dir,
    input  logic         we_type,
    input  logic         we_pull,
    input  logic         we_set,
    input  logic         we_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] type_q,
    output logic [W-1:0] pull_q,
    output logic [W-1:0] out_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            type_q <= '0;
            pull_q <= '0;
            out_q  <= '0;
        end else begin
            if (we_dir)  dir_q  <= wdata;
            if (we_type) type_q <= wdata;
            if (we_pull) pull_q <= wdata;
            if (we_clr)
                out_q <= out_q & ~wdata;
            else if (we_set)
                out_q <= out_q | wdata;
        end
    end

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (we_set && !we_clr) |=> ((out_q & $past(wdata)) == $past(wdata))); // R5
    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        we_clr |=> ((out_q & $past(wdata)) == '0)); // R6
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_set && !we_clr) |=> $stable(out_q)); // R5
endmodule

// File: rtl/gpx_pad_decode.sv
module gpx_pad_decode (
    input  logic avail,
    input  logic dir,
    input  logic typ,
    input  logic pul,
    input  logic latch,
    output logic p_out,
    output logic p_oe,
    output logic p_od,
    output logic p_pu,
    output logic p_pd,
    output logic p_ana
);
    always_comb begin
        p_out = 1'b0;
        p_oe  = 1'b0;
        p_od  = 1'b0;
        p_pu  = 1'b0;
        p_pd  = 1'b0;
        p_ana = 1'b0;
        if (avail) begin
            if (dir) begin
                p_oe  = 1'b1;
                p_out = latch;
                p_od  = typ;
                p_pu  = typ & pul;
            end else if (typ) begin
                p_pu = pul;
                p_pd = ~pul;
            end else begin
                p_ana = ~pul;
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    parameter int NUM_GRPS  = 2,
    parameter int GRP_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [7:0]                  addr,
    input  logic [BANK_W-1:0]           wdata,
    output logic [BANK_W-1:0]           rdata,
    input  logic [NUM_GRPS-1:0]         grp_en,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    output logic [NUM_BANKS*BANK_W-1:0] pad_out,
    output logic [NUM_BANKS*BANK_W-1:0] pad_oe,
    output logic [NUM_BANKS*BANK_W-1:0] pad_od,
    output logic [NUM_BANKS*BANK_W-1:0] pad_pu,
    output logic [NUM_BANKS*BANK_W-1:0] pad_pd,
    output logic [NUM_BANKS*BANK_W-1:0] pad_ana
);
    import gpx_pkg::*;

    localparam int NPINS       = NUM_BANKS * BANK_W;
    localparam int ALWAYS_PINS = NPINS - NUM_GRPS * GRP_W;

    logic [NUM_BANKS-1:0] hit_st, hit_dir, hit_typ, hit_pul, hit_set, hit_clr;
    logic [NPINS-1:0]     dir_q, type_q, pull_q, out_q, pin_sync, avail, state_vis;
    logic [BANK_W-1:0]    rd_mux;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign hit_st[b]  = (addr == BASE_STATE + 8'(b));
        assign hit_dir[b] = (addr == dir_addr(b));
        assign hit_typ[b] = (addr == BASE_TYPE + 8'(b));
        assign hit_pul[b] = (addr == BASE_PULL + 8'(b));
        assign hit_set[b] = (addr == BASE_SET + 8'(b));
        assign hit_clr[b] = (addr == BASE_CLR + 8'(b));

        gpx_bank #(.W(BANK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_dir  (wr_en & hit_dir[b]),
            .we_type (wr_en & hit_typ[b]),
            .we_pull (wr_en & hit_pul[b]),
            .we_set  (wr_en & hit_set[b]),
            .we_clr  (wr_en & hit_clr[b]),
            .wdata   (wdata),
            .dir_q   (dir_q[b*BANK_W +: BANK_W]),
            .type_q  (type_q[b*BANK_W +: BANK_W]),
            .pull_q  (pull_q[b*BANK_W +: BANK_W]),
            .out_q   (out_q[b*BANK_W +: BANK_W])
        );
    end

    gpx_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        if (p < ALWAYS_PINS) begin : g_fixed
            assign avail[p] = 1'b1;
        end else begin : g_gated
            assign avail[p] = grp_en[(p - ALWAYS_PINS) / GRP_W];
        end

        gpx_pad_decode u_dec (
            .avail (avail[p]),
            .dir   (dir_q[p]),
            .typ   (type_q[p]),
            .pul   (pull_q[p]),
            .latch (out_q[p]),
            .p_out (pad_out[p]),
            .p_oe  (pad_oe[p]),
            .p_od  (pad_od[p]),
            .p_pu  (pad_pu[p]),
            .p_pd  (pad_pd[p]),
            .p_ana (pad_ana[p])
        );
    end

    assign state_vis = pin_sync & avail;

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_st[b])              rd_mux = rd_mux | state_vis[b*BANK_W +: BANK_W];
            if (hit_dir[b])             rd_mux = rd_mux | dir_q[b*BANK_W +: BANK_W];
            if (hit_typ[b])             rd_mux = rd_mux | type_q[b*BANK_W +: BANK_W];
            if (hit_pul[b])             rd_mux = rd_mux | pull_q[b*BANK_W +: BANK_W];
            if (hit_set[b] | hit_clr[b]) rd_mux = rd_mux | out_q[b*BANK_W +: BANK_W];
        end
    end

    assign rdata = rd_en ? rd_mux : '0;

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_pd) == '0)); // R8
    AST_DRIVE_NOT_ANALOG: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & (pad_pd | pad_ana)) == '0)); // R7
    AST_GROUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((~avail & (pad_out | pad_oe | pad_od | pad_pu | pad_pd | pad_ana)) == '0)); // R9
    AST_OD_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_od & ~pad_oe) == '0)); // R7
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [1:0]  grp_en = 2'b00;
    logic [23:0] pin_in = 24'h0;
    logic [23:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd, pad_ana;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .grp_en(grp_en), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .pad_ana(pad_ana)
    );

    // Behavioural reference model
    logic [23:0] m_dir, m_typ, m_pul, m_out, m_s1, m_s2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir <= 0; m_typ <= 0; m_pul <= 0; m_out <= 0; m_s1 <= 0; m_s2 <= 0;
        end else begin
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            if (wr_en) begin
                case (addr)
                    8'h60: m_dir[7:0]   <= wdata;
                    8'h61: m_dir[15:8]  <= wdata;
                    8'h63: m_dir[23:16] <= wdata;
                    8'h64: m_typ[7:0]   <= wdata;
                    8'h65: m_typ[15:8]  <= wdata;
                    8'h66: m_typ[23:16] <= wdata;
                    8'h68: m_pul[7:0]   <= wdata;
                    8'h69: m_pul[15:8]  <= wdata;
                    8'h6A: m_pul[23:16] <= wdata;
                    8'h6C: m_out[7:0]   <= m_out[7:0] | wdata;
                    8'h6D: m_out[15:8]  <= m_out[15:8] | wdata;
                    8'h6E: m_out[23:16] <= m_out[23:16] | wdata;
                    8'h70: m_out[7:0]   <= m_out[7:0] & ~wdata;
                    8'h71: m_out[15:8]  <= m_out[15:8] & ~wdata;
                    8'h72: m_out[23:16] <= m_out[23:16] & ~wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [23:0] m_avail();
        return {{4{grp_en[1]}}, {4{grp_en[0]}}, 16'hFFFF};
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        logic [23:0] st;
        st = m_s2 & m_avail();
        case (a)
            8'h10: return st[7:0];
            8'h11: return st[15:8];
            8'h12: return st[23:16];
            8'h60: return m_dir[7:0];
            8'h61: return m_dir[15:8];
            8'h63: return m_dir[23:16];
            8'h64: return m_typ[7:0];
            8'h65: return m_typ[15:8];
            8'h66: return m_typ[23:16];
            8'h68: return m_pul[7:0];
            8'h69: return m_pul[15:8];
            8'h6A: return m_pul[23:16];
            8'h6C, 8'h70: return m_out[7:0];
            8'h6D, 8'h71: return m_out[15:8];
            8'h6E, 8'h72: return m_out[23:16];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        if (a >= 8'h10 && a <= 8'h12) return "R2";
        if (a == 8'h60 || a == 8'h61 || a == 8'h63) return "R3";
        if ((a >= 8'h64 && a <= 8'h66) || (a >= 8'h68 && a <= 8'h6A)) return "R4";
        if (a >= 8'h6C && a <= 8'h6E) return "R5";
        if (a >= 8'h70 && a <= 8'h72) return "R6";
        return "R11";
    endfunction

    // {out, oe, od, pu, pd, ana}
    function automatic logic [5:0] m_pad(input int n);
        logic av, o, p;
        av = m_avail()[n];
        o = m_out[n];
        p = m_pul[n];
        if (!av) return 6'b0;
        if (m_dir[n]) begin
            if (m_typ[n]) return {o, 1'b1, 1'b1, p, 1'b0, 1'b0};
            return {o, 1'b1, 4'b0000};
        end
        if (m_typ[n]) return {3'b000, p, ~p, 1'b0};
        return {5'b00000, ~p};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int n = 0; n < 24; n++) begin
                logic [5:0] act;
                act = {pad_out[n], pad_oe[n], pad_od[n], pad_pu[n], pad_pd[n], pad_ana[n]};
                if (!m_avail()[n]) check("R9", {26'd0, act}, {26'd0, m_pad(n)});
                else if (m_dir[n]) check("R7", {26'd0, act}, {26'd0, m_pad(n)});
                else check("R8", {26'd0, act}, {26'd0, m_pad(n)});
            end
            if (rd_en) check(read_tag(addr), {24'd0, rdata}, {24'd0, m_read(addr)});
            else check("R11", {24'd0, rdata}, 32'd0);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); #2;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk); #2;
        rd_en = 1'b1; addr = a;
        @(negedge clk); #2;
        rd_en = 1'b0;
    endtask

    task automatic sweep();
        for (int a = 0; a < 256; a++) rd(8'(a));
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [23:0] lfsr;
        lfsr = 24'hACE1B5;
        repeat (5) @(negedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #2;
        // R10: reset state is analog input on every always-available pin
        check("R10", {8'd0, pad_ana}, 32'h00FFFF);
        check("R10", {8'd0, pad_oe}, 32'h0);
        sweep();

        grp_en = 2'b11;
        wr(8'h60, 8'hF0); wr(8'h61, 8'h0F); wr(8'h63, 8'hAA);
        wr(8'h62, 8'hFF);                  // R3: hole, ignored
        wr(8'h64, 8'hCC); wr(8'h65, 8'h33); wr(8'h66, 8'h5A);
        wr(8'h68, 8'hA5); wr(8'h69, 8'h0F); wr(8'h6A, 8'hF0);
        wr(8'h6C, 8'hFF); wr(8'h6D, 8'h3C); wr(8'h6E, 8'h81);
        wr(8'h70, 8'h0F);
        wr(8'h10, 8'hFF);                  // R2: read-only, ignored
        // R1: pin 10 is bank 1 bit 2 (output, latch 1); pin 13 is input
        check("R1", {31'd0, pad_out[10]}, 32'd1);
        check("R1", {31'd0, pad_out[13]}, 32'd0);
        check("R3", {31'd0, pad_oe[23]}, 32'd1);
        sweep();

        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #2;
            lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
            pin_in = lfsr;
            rd_en = 1'b1;
            addr = 8'h10 + 8'(i % 3);
        end
        @(negedge clk); #2 rd_en = 1'b0;

        wr(8'h71, 8'hFF); wr(8'h6D, 8'h81); wr(8'h72, 8'h01);
        wr(8'h64, 8'h00); wr(8'h68, 8'hFF);
        grp_en = 2'b01; sweep();
        grp_en = 2'b10; sweep();
        grp_en = 2'b00; sweep();
        grp_en = 2'b11;
        rd(8'h12); rd(8'h6E); rd(8'h63);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule